// File: doc/BRIEF.md
# Life-Cycle Transition Sequencer

This block is the control state machine that carries a device from one life-cycle state to another. Once it is out of reset and idle, a transition request starts a fixed sequence of steps. The clock source is switched. The transition counter is checked and reprogrammed. The legality of the requested transition is checked. The supplied unlock token is hashed. An optional flash wipe runs. The hashed token is compared in two halves. Finally the new state is written. Every step that can fail drops the sequence into one terminal post-transition state. The surrounding logic then waits for a reset.

The clock mux, the hash engine, the flash wiper and the non-volatile programmer all sit outside the block. Each is reached through a request line that stays high until an acknowledge arrives, and most of them return an error flag alongside the acknowledge.

Two independent escalation inputs override everything. Either one alone sends the machine to an escalate state on the next edge, whatever state it is in. The state register uses a sparse code. Any value outside the fifteen legal codes is caught and steered into an invalid state.

Top module: `lcx_seq_fsm`

## Requirements
- R1: While reset is low, `state_o` shows the Reset code. The first clock edge after reset is released moves the machine to Idle.
- R2: In Idle, `scrap_i` moves the machine to Scrap, and `scrap_i` wins over `trans_req_i`. Otherwise `trans_req_i` moves it to ClkMux. With neither input high, it stays in Idle.
- R3: ClkMux holds `clk_sw_req_o` high and moves to CntIncr on the edge where `clk_sw_ack_i` is high.
- R4: CntIncr is one cycle long. If `cnt_val_i` is all ones, it goes to PostTrans; otherwise it goes to CntProg. In every cycle `cnt_next_o` equals `cnt_val_i + 1`.
- R5: CntProg holds `cnt_prog_req_o` high. On acknowledge it goes to PostTrans if `cnt_prog_err_i` is set, and to TransCheck if it is not.
- R6: TransCheck is one cycle long. It goes to TokenHash if `trans_ok_i` is high, and to PostTrans if it is low.
- R7: TokenHash holds `hash_req_o` high. An acknowledge with an error goes to PostTrans. An acknowledge without an error stores `hash_val_i` and goes to FlashRma.
- R8: In FlashRma with `wipe_need_i` high, `wipe_req_o` stays high until `wipe_ack_i` arrives, and the machine then goes to TokenCheck0. With `wipe_need_i` low, `wipe_req_o` is never raised and the machine leaves after one cycle.
- R9: TokenCheck0 compares the low half of the stored hash with `exp_tok_i`, and TokenCheck1 compares the high half. Each check lasts exactly one cycle. A match advances (TokenCheck0 to TokenCheck1, TokenCheck1 to TransProg). A mismatch goes to PostTrans.
- R10: TransProg holds `st_prog_req_o` high and goes to PostTrans on acknowledge. `ok_o` is 1 afterwards only if `st_prog_err_i` was low with that acknowledge; otherwise it stays 0.
- R11: PostTrans, Scrap, Escalate and Invalid hold until reset unless escalation is raised.
- R12: `esc_a_i` or `esc_b_i` high at an edge puts the machine in Escalate after that edge, from any state. This takes priority over every other condition.
- R13: State codes are `{n,n,n,~n}`, with a 4-bit index n taken in this order: Reset 0, Idle 1, ClkMux 2, CntIncr 3, CntProg 4, TransCheck 5, TokenHash 6, FlashRma 7, TokenCheck0 8, TokenCheck1 9, TransProg 10, PostTrans 11, Scrap 12, Escalate 13, Invalid 14. Any other value in the state register leads to Invalid on the next edge.
- R14: At most one request output is high at a time, and each one is high only in its own state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trans_req_i | input | 1 | Start a transition from Idle |
| scrap_i | input | 1 | Scrap condition seen in Idle |
| esc_a_i | input | 1 | Escalation input A |
| esc_b_i | input | 1 | Escalation input B |
| cnt_val_i | input | CNT_W | Current transition count |
| cnt_next_o | output | CNT_W | Incremented count to program |
| clk_sw_req_o | output | 1 | Clock switch request |
| clk_sw_ack_i | input | 1 | Clock switch acknowledge |
| cnt_prog_req_o | output | 1 | Counter program request |
| cnt_prog_ack_i | input | 1 | Counter program acknowledge |
| cnt_prog_err_i | input | 1 | Counter program error |
| trans_ok_i | input | 1 | Requested transition is legal |
| hash_req_o | output | 1 | Token hash request |
| hash_ack_i | input | 1 | Token hash acknowledge |
| hash_err_i | input | 1 | Token hash error |
| hash_val_i | input | TOK_W | Hashed token |
| wipe_need_i | input | 1 | Transition requires a flash wipe |
| wipe_req_o | output | 1 | Flash wipe request |
| wipe_ack_i | input | 1 | Flash wipe acknowledge |
| exp_tok_i | input | TOK_W | Expected hashed token |
| st_prog_req_o | output | 1 | New state program request |
| st_prog_ack_i | input | 1 | State program acknowledge |
| st_prog_err_i | input | 1 | State program error |
| state_o | output | 16 | Current state code |
| ok_o | output | 1 | Last state program succeeded |

## Verification
The bench walks every early exit and records which state came just before PostTrans. A step that skipped its check, or jumped to the wrong stage, would show the wrong final step. Token vectors corrupt only one half of the hash at a time. An implementation that compared the wrong half, or compared the whole word in one stage, would exit one state early or late. Runs with and without a wipe check whether `wipe_req_o` is raised at all. Escalation is driven on each input separately, in Idle, mid-sequence and in PostTrans, to catch a design that ORs them wrongly or lets a terminal state ignore them. A state code forced outside the legal set must land in Invalid rather than fall through to some legal state.

// File: rtl/lcx_pkg.sv
package lcx_pkg;
    localparam int IDX_W  = 4;
    localparam int ST_W   = 4 * IDX_W;
    localparam int NUM_ST = 15;

    typedef logic [ST_W-1:0] state_t;

    // Three copies of the index plus its inverse: any two codes differ in at least four bits
    function automatic state_t code_of(input int unsigned idx);
        logic [IDX_W-1:0] n;
        n = idx[IDX_W-1:0];
        return {n, n, n, ~n};
    endfunction

    localparam state_t ST_RESET   = code_of(0);
    localparam state_t ST_IDLE    = code_of(1);
    localparam state_t ST_CLKMUX  = code_of(2);
    localparam state_t ST_CNTINC  = code_of(3);
    localparam state_t ST_CNTPRG  = code_of(4);
    localparam state_t ST_TRCHK   = code_of(5);
    localparam state_t ST_HASH    = code_of(6);
    localparam state_t ST_WIPE    = code_of(7);
    localparam state_t ST_TOKLO   = code_of(8);
    localparam state_t ST_TOKHI   = code_of(9);
    localparam state_t ST_STPRG   = code_of(10);
    localparam state_t ST_POST    = code_of(11);
    localparam state_t ST_SCRAP   = code_of(12);
    localparam state_t ST_ESC     = code_of(13);
    localparam state_t ST_INVALID = code_of(14);
endpackage

// File: rtl/lcx_legal_chk.sv
module lcx_legal_chk
    import lcx_pkg::*;
(
    input  state_t st_i,
    output logic   legal_o
);
    logic [NUM_ST-1:0] hit;

    for (genvar g = 0; g < NUM_ST; g++) begin : g_code
        assign hit[g] = (st_i == code_of(g));
    end

    assign legal_o = |hit;
endmodule

// File: rtl/lcx_tok_cmp.sv
module lcx_tok_cmp #(
    parameter int TOK_W = 32
) (
    input  logic [TOK_W-1:0] got_i,
    input  logic [TOK_W-1:0] exp_i,
    output logic             lo_eq_o,
    output logic             hi_eq_o
);
    localparam int HALF = TOK_W / 2;
    logic [1:0] eq;

    for (genvar g = 0; g < 2; g++) begin : g_half
        assign eq[g] = (got_i[g*HALF +: HALF] == exp_i[g*HALF +: HALF]);
    end

    assign lo_eq_o = eq[0];
    assign hi_eq_o = eq[1];
endmodule

// File: rtl/lcx_seq_fsm.sv
module lcx_seq_fsm
    import lcx_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TOK_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trans_req_i,
    input  logic             scrap_i,
    input  logic             esc_a_i,
    input  logic             esc_b_i,
    input  logic [CNT_W-1:0] cnt_val_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             clk_sw_req_o,
    input  logic             clk_sw_ack_i,
    output logic             cnt_prog_req_o,
    input  logic             cnt_prog_ack_i,
    input  logic             cnt_prog_err_i,
    input  logic             trans_ok_i,
    output logic             hash_req_o,
    input  logic             hash_ack_i,
    input  logic             hash_err_i,
    input  logic [TOK_W-1:0] hash_val_i,
    input  logic             wipe_need_i,
    output logic             wipe_req_o,
    input  logic             wipe_ack_i,
    input  logic [TOK_W-1:0] exp_tok_i,
    output logic             st_prog_req_o,
    input  logic             st_prog_ack_i,
    input  logic             st_prog_err_i,
    output logic [15:0]      state_o,
    output logic             ok_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [TOK_W-1:0] tok;
        logic             ok;
    } dat_t;

    state_t st_d, st_q;
    dat_t   dat_d, dat_q;
    logic   legal, lo_eq, hi_eq, esc;

    assign esc = esc_a_i | esc_b_i;

    lcx_legal_chk u_legal (
        .st_i    (st_q),
        .legal_o (legal)
    );

    lcx_tok_cmp #(.TOK_W(TOK_W)) u_cmp (
        .got_i   (dat_q.tok),
        .exp_i   (exp_tok_i),
        .lo_eq_o (lo_eq),
        .hi_eq_o (hi_eq)
    );

    always_comb begin
        st_d  = st_q;
        dat_d = dat_q;
        if (!legal) begin
            st_d = ST_INVALID;
        end else begin
            case (st_q)
                ST_RESET:  st_d = ST_IDLE;
                ST_IDLE: begin
                    if (scrap_i)          st_d = ST_SCRAP;
                    else if (trans_req_i) st_d = ST_CLKMUX;
                end
                ST_CLKMUX: if (clk_sw_ack_i) st_d = ST_CNTINC;
                ST_CNTINC: st_d = (cnt_val_i == CNT_MAX) ? ST_POST : ST_CNTPRG;
                ST_CNTPRG: if (cnt_prog_ack_i) st_d = cnt_prog_err_i ? ST_POST : ST_TRCHK;
                ST_TRCHK:  st_d = trans_ok_i ? ST_HASH : ST_POST;
                ST_HASH: begin
                    if (hash_ack_i) begin
                        if (hash_err_i) begin
                            st_d = ST_POST;
                        end else begin
                            st_d      = ST_WIPE;
                            dat_d.tok = hash_val_i;
                        end
                    end
                end
                ST_WIPE:   if (!wipe_need_i || wipe_ack_i) st_d = ST_TOKLO;
                ST_TOKLO:  st_d = lo_eq ? ST_TOKHI : ST_POST;
                ST_TOKHI:  st_d = hi_eq ? ST_STPRG : ST_POST;
                ST_STPRG: begin
                    if (st_prog_ack_i) begin
                        st_d     = ST_POST;
                        dat_d.ok = !st_prog_err_i;
                    end
                end
                default:   st_d = st_q;
            endcase
        end
        if (esc) st_d = ST_ESC;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= ST_RESET;
            dat_q <= '0;
        end else begin
            st_q  <= st_d;
            dat_q <= dat_d;
        end
    end

    assign clk_sw_req_o   = (st_q == ST_CLKMUX);
    assign cnt_prog_req_o = (st_q == ST_CNTPRG);
    assign hash_req_o     = (st_q == ST_HASH);
    assign wipe_req_o     = (st_q == ST_WIPE) && wipe_need_i;
    assign st_prog_req_o  = (st_q == ST_STPRG);
    assign cnt_next_o     = cnt_val_i + CNT_ONE;
    assign state_o        = st_q;
    assign ok_o           = dat_q.ok;

    p_reset_exit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_RESET && !esc) |=> (st_q == ST_IDLE));
    p_tokhi_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_TOKHI) |=> (st_q != ST_TOKHI));
    p_term_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == ST_POST || st_q == ST_SCRAP || st_q == ST_ESC || st_q == ST_INVALID) && !esc)
        |=> $stable(st_q));
    p_esc_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        esc |=> (st_q == ST_ESC));
    p_illegal_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!legal && !esc) |=> (st_q == ST_INVALID));
    p_one_req_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({clk_sw_req_o, cnt_prog_req_o, hash_req_o, wipe_req_o, st_prog_req_o}));
    p_wipe_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_WIPE && !wipe_need_i && !esc) |=> (st_q == ST_TOKLO));
endmodule

// File: tb/sim_lcx_seq_fsm.sv
`timescale 1ns/1ps
module sim_lcx_seq_fsm;
    import lcx_pkg::*;

    localparam int CNT_W = 8;
    localparam int TOK_W = 32;
    localparam logic [TOK_W-1:0] EXP_TOK = 32'hA5C3_1E77;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_ni, trans_req, scrap, esc_a, esc_b;
    logic [CNT_W-1:0] cnt_val, cnt_next;
    logic clk_sw_req, clk_sw_ack, cnt_prog_req, cnt_prog_ack, cnt_prog_err, trans_ok;
    logic hash_req, hash_ack, hash_err, wipe_need, wipe_req, wipe_ack;
    logic st_prog_req, st_prog_ack, st_prog_err, ok;
    logic [TOK_W-1:0] hash_val;
    logic [15:0] state;

    lcx_seq_fsm #(.CNT_W(CNT_W), .TOK_W(TOK_W)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .trans_req_i(trans_req), .scrap_i(scrap),
        .esc_a_i(esc_a), .esc_b_i(esc_b), .cnt_val_i(cnt_val), .cnt_next_o(cnt_next),
        .clk_sw_req_o(clk_sw_req), .clk_sw_ack_i(clk_sw_ack),
        .cnt_prog_req_o(cnt_prog_req), .cnt_prog_ack_i(cnt_prog_ack), .cnt_prog_err_i(cnt_prog_err),
        .trans_ok_i(trans_ok), .hash_req_o(hash_req), .hash_ack_i(hash_ack), .hash_err_i(hash_err),
        .hash_val_i(hash_val), .wipe_need_i(wipe_need), .wipe_req_o(wipe_req), .wipe_ack_i(wipe_ack),
        .exp_tok_i(EXP_TOK), .st_prog_req_o(st_prog_req), .st_prog_ack_i(st_prog_ack),
        .st_prog_err_i(st_prog_err), .state_o(state), .ok_o(ok)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Vector bits: [3:0] index of last state before PostTrans, [4] expected ok,
    // [5] counter at max, [6] counter program error, [7] illegal transition,
    // [8] hash error, [9] wipe needed, [10] low half bad, [11] high half bad, [12] state program error
    localparam int NV = 10;
    localparam logic [12:0] VEC [NV] = '{
        13'h001A, 13'h021A, 13'h0023, 13'h0044, 13'h0085,
        13'h0106, 13'h0408, 13'h0809, 13'h100A, 13'h0A09
    };

    task automatic check(input logic cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        clk_sw_ack   = clk_sw_req   & ~clk_sw_ack;
        cnt_prog_ack = cnt_prog_req & ~cnt_prog_ack;
        hash_ack     = hash_req     & ~hash_ack;
        wipe_ack     = wipe_req     & ~wipe_ack;
        st_prog_ack  = st_prog_req  & ~st_prog_ack;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0;
        {trans_req, scrap, esc_a, esc_b} = '0;
        {clk_sw_ack, cnt_prog_ack, hash_ack, wipe_ack, st_prog_ack} = '0;
        step();
        rst_ni = 1'b1;
        step();
    endtask

    task automatic set_vec(input logic [12:0] v);
        cnt_val      = v[5] ? 8'hFF : 8'h3C;
        cnt_prog_err = v[6];
        trans_ok     = !v[7];
        hash_err     = v[8];
        wipe_need    = v[9];
        hash_val     = EXP_TOK ^ (v[10] ? 32'h0000_0100 : 32'h0) ^ (v[11] ? 32'h0400_0000 : 32'h0);
        st_prog_err  = v[12];
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_ni = 1'b0;
        {trans_req, scrap, esc_a, esc_b} = '0;
        {clk_sw_ack, cnt_prog_ack, hash_ack, wipe_ack, st_prog_ack} = '0;
        set_vec(13'h001A);
        @(negedge clk);
        @(negedge clk);
        check(state == ST_RESET, "R1 reset state", state, ST_RESET);
        rst_ni = 1'b1;
        step();
        check(state == ST_IDLE, "R1 idle after reset", state, ST_IDLE);
        step();
        check(state == ST_IDLE, "R2 idle holds", state, ST_IDLE);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] prev;
            logic wipe_seen, tokhi_twice, cnt_ok;
            set_vec(VEC[i]);
            do_reset();
            trans_req = 1'b1;
            step();
            trans_req = 1'b0;
            check(state == ST_CLKMUX, "R2 request starts chain", state, ST_CLKMUX);
            check(clk_sw_req, "R3 clock switch request", clk_sw_req, 1);
            prev = ST_IDLE; wipe_seen = 1'b0; tokhi_twice = 1'b0; cnt_ok = 1'b1;
            for (int k = 0; k < 60; k++) begin
                if (state == ST_POST) break;
                if (wipe_req) wipe_seen = 1'b1;
                if (prev == ST_TOKHI && state == ST_TOKHI) tokhi_twice = 1'b1;
                if (state == ST_CNTPRG && cnt_next != cnt_val + 8'd1) cnt_ok = 1'b0;
                prev = state;
                step();
            end
            check(state == ST_POST, "R11 ends in PostTrans", state, ST_POST);
            check(prev == code_of(int'(VEC[i][3:0])), "R4 R5 R6 R7 R9 R10 exit point",
                  prev, code_of(int'(VEC[i][3:0])));
            check(ok == VEC[i][4], "R10 ok flag", ok, VEC[i][4]);
            check(wipe_seen == (VEC[i][9] && VEC[i][3:0] >= 4'd8), "R8 wipe request",
                  wipe_seen, VEC[i][9]);
            check(!tokhi_twice, "R9 TokenCheck1 single cycle", tokhi_twice, 0);
            check(cnt_ok, "R4 counter increment", cnt_next, cnt_val + 8'd1);
            step();
            check(state == ST_POST, "R11 PostTrans holds", state, ST_POST);
        end

        set_vec(13'h001A);
        do_reset();
        scrap = 1'b1; trans_req = 1'b1;
        step();
        scrap = 1'b0; trans_req = 1'b0;
        check(state == ST_SCRAP, "R2 scrap wins", state, ST_SCRAP);
        step(); step();
        check(state == ST_SCRAP, "R11 scrap holds", state, ST_SCRAP);

        do_reset();
        esc_a = 1'b1;
        step();
        esc_a = 1'b0;
        check(state == ST_ESC, "R12 esc A from Idle", state, ST_ESC);
        step(); step();
        check(state == ST_ESC, "R11 escalate holds", state, ST_ESC);

        do_reset();
        trans_req = 1'b1;
        step();
        trans_req = 1'b0;
        step(); step(); step();
        esc_b = 1'b1;
        step();
        esc_b = 1'b0;
        check(state == ST_ESC, "R12 esc B mid-sequence", state, ST_ESC);
        check(!(clk_sw_req | cnt_prog_req | hash_req | wipe_req | st_prog_req),
              "R14 no request in Escalate", 1, 0);

        do_reset();
        trans_req = 1'b1;
        for (int k = 0; k < 40; k++) begin
            step();
            trans_req = 1'b0;
            if (state == ST_POST) break;
        end
        esc_b = 1'b1;
        step();
        esc_b = 1'b0;
        check(state == ST_ESC, "R12 esc B from PostTrans", state, ST_ESC);

        do_reset();
        @(negedge clk);
        force u0.st_q = 16'h1234;
        #1;
        release u0.st_q;
        step();
        check(state == ST_INVALID, "R13 illegal code to Invalid", state, ST_INVALID);
        step();
        check(state == ST_INVALID, "R11 Invalid holds", state, ST_INVALID);
        esc_a = 1'b1;
        step();
        esc_a = 1'b0;
        check(state == ST_ESC, "R12 esc from Invalid", state, ST_ESC);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule